// File: doc/BRIEF.md
# Buffered Partition Loader and Checker

This controller owns one buffered partition of a one-time-programmable memory. After an init request it fetches the partition one block at a time through a request/grant/read-valid memory port. When the partition is built as scrambled, each data block goes through an external descrambler before it is stored. The descrambler is reached through a mutex-guarded valid/ready handshake. The final block of the partition holds the stored digest and is kept in the buffer exactly as read.

Once every block has been loaded, the controller recomputes the digest over the data blocks and compares the result with the stored digest. The recomputation uses the external engine and feeds it the blocks in pairs. Init completes only when this comparison passes. A stored digest of zero is treated as "not yet locked" and always passes.

From idle, a requester can start two kinds of check:
- a consistency check, which reads the digest location back from memory;
- an integrity check, which repeats the digest recomputation.

A check that passes produces a one-cycle acknowledge. The error code is sticky, and a failure or an escalation puts the controller in a terminal error state. Two lock outputs carry a multi-bit flag that is asserted whenever the buffered digest is nonzero.

Top module: `pbuf_ctrl`

## Requirements
- R1: While reset is held and right after it, `init_done_o` is 0, `err_o` is 0 (none), `mem_req_o` is 0, and both lock outputs carry the false code 8'h69.
- R2: Until init completes, every byte of `data_o` reads 8'hC3. After init, block i of the buffer appears at `data_o[i*BW +: BW]`. Data blocks hold descrambled contents, and the last block holds the stored digest as read from memory.
- R3: A memory read holds `mem_req_o` high until `mem_gnt_i` is seen. The read status uses 0 for clean, 1 for corrected and 2 or 3 for uncorrectable. An uncorrectable status records code 2 (check fail), enters the error state and leaves init incomplete.
- R4: A read with status 1 is accepted like a clean read and records code 1 (corrected ECC).
- R5: A descramble or digest transfer happens only in a cycle where `scr_gnt_i` and `scr_ready_i` are both high. While either one is withheld, init makes no progress.
- R6: After the last block is read, the data blocks are digested in pairs: the even-indexed block goes in the low half of `scr_data_o`, the odd-indexed block in the high half, with command 1. Command 2 then finalizes. Init completes only if the returned digest equals the stored digest or the stored digest is zero.
- R7: When the integrity recomputation does not match a nonzero stored digest, the controller records code 2 and enters the error state.
- R8: A consistency request in idle reads memory address NB-1. It acknowledges when the value read equals the buffered digest or the buffered digest is zero. Otherwise it records code 2 and enters the error state.
- R9: An integrity request in idle repeats the R6 recomputation and acknowledges on a match.
- R10: Both lock outputs are 8'h96 when the buffered digest is nonzero and 8'h69 when it is zero.
- R11: Escalation forces the error state. It records code 3 (FSM fault) only when no code has yet been recorded, and otherwise leaves the code unchanged.
- R12: The error state lasts until reset. While in it, check requests cause no memory request, no mutex request and no acknowledge.
- R13: Code 2 may replace code 1, and no recorded code returns to 0 before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req_i | input | 1 | Start loading the partition |
| init_done_o | output | 1 | Partition loaded and verified |
| integ_req_i | input | 1 | Request integrity check (idle only) |
| cnsty_req_i | input | 1 | Request consistency check (idle only) |
| chk_ack_o | output | 1 | One-cycle pulse on a passed check |
| esc_i | input | 1 | Escalation, forces error state |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | CW | Block index to read |
| mem_gnt_i | input | 1 | Memory grant |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | BW | Read data |
| mem_status_i | input | 2 | Read status: 0 clean, 1 corrected, 2/3 uncorrectable |
| mtx_req_o | output | 1 | Request for the engine mutex |
| scr_gnt_i | input | 1 | Mutex grant |
| scr_ready_i | input | 1 | Engine ready |
| scr_vld_o | output | 1 | Engine command valid |
| scr_cmd_o | output | 2 | 0 descramble, 1 absorb pair, 2 finalize |
| scr_data_o | output | 2*BW | Engine operand (pair: high = odd block) |
| scr_vld_i | input | 1 | Engine result valid |
| scr_data_i | input | BW | Engine result |
| data_o | output | NB*BW | Buffered partition contents |
| err_o | output | 2 | Sticky error code |
| rd_lock_o | output | 8 | Read lock flag |
| wr_lock_o | output | 8 | Write lock flag |

## Verification
The bench builds the controller with NB=5, BW=64 and SCRAMBLED=1. These values give four data blocks, so the digest is fed as exactly two pairs, and the pair-counting and penultimate-block logic is exercised. The scrambled build also brings the descramble handshake into every init and lets the mutex and ready stalls be tested. Because the memory and engine models are part of the bench, the bench can inject corrected and uncorrectable read status, corrupt the stored digest, and clear the stored digest to zero.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0,
        ERR_ECC  = 2'd1,
        ERR_CHK  = 2'd2,
        ERR_FSM  = 2'd3
    } err_e;

    typedef enum logic [1:0] {
        CMD_DESCR  = 2'd0,
        CMD_ABSORB = 2'd1,
        CMD_FINAL  = 2'd2
    } scr_cmd_e;

    typedef enum logic [3:0] {
        S_RESET, S_RD, S_RDW, S_DSC, S_DSCW, S_DIGCLR, S_DIG,
        S_FIN, S_FINW, S_IDLE, S_CNRD, S_CNRDW, S_ERR
    } st_e;

    localparam logic [7:0] LOCK_ON   = 8'h96;
    localparam logic [7:0] LOCK_OFF  = 8'h69;
    localparam logic [7:0] DFLT_BYTE = 8'hC3;

    function automatic logic [7:0] lock_code(input logic nonzero);
        return nonzero ? LOCK_ON : LOCK_OFF;
    endfunction

    function automatic logic read_ok(input logic [1:0] status);
        return status <= 2'd1;
    endfunction

endpackage

// File: rtl/pbuf_cnt.sv
module pbuf_cnt #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          err
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] shd_q;   // holds the inverse of cnt_q

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            shd_q <= '1;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
            shd_q <= shd_q - 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign err = (cnt_q != ~shd_q);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R6
    AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/pbuf_store.sv
module pbuf_store
    import pbuf_pkg::*;
#(
    parameter int NB = 5,
    parameter int BW = 64,
    parameter int CW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CW-1:0]    widx,
    input  logic [BW-1:0]    wdata,
    input  logic [CW-1:0]    ridx,
    input  logic             done,
    output logic [BW-1:0]    rblk,
    output logic [BW-1:0]    digest,
    output logic [NB*BW-1:0] data_o
);
    logic [BW-1:0]    blk_q [NB];
    logic [NB*BW-1:0] flat;

    for (genvar i = 0; i < NB; i++) begin : g_blk
        always_ff @(posedge clk) begin
            if (rst) blk_q[i] <= '0;
            else if (we && widx == CW'(i)) blk_q[i] <= wdata;
        end
        assign flat[i*BW +: BW] = blk_q[i];
    end

    always_comb begin
        rblk = '0;
        for (int i = 0; i < NB; i++)
            if (ridx == CW'(i)) rblk = blk_q[i];
    end

    assign digest = blk_q[NB-1];
    assign data_o = done ? flat : {(NB*BW/8){DFLT_BYTE}};

endmodule

// File: rtl/pbuf_err.sv
module pbuf_err
    import pbuf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_ecc,
    input  logic set_chk,
    input  logic set_fsm,
    output err_e err
);
    err_e err_q;

    always_ff @(posedge clk) begin
        if (rst) err_q <= ERR_NONE;
        else if (set_chk && (err_q == ERR_NONE || err_q == ERR_ECC)) err_q <= ERR_CHK;
        else if (set_fsm && err_q == ERR_NONE) err_q <= ERR_FSM;
        else if (set_ecc && err_q == ERR_NONE) err_q <= ERR_ECC;
    end

    assign err = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_NONE) |=> (err_q != ERR_NONE)); // R13
    AST_FSM_FROM_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (err_q != ERR_FSM) |=> (err_q != ERR_FSM || $past(err_q) == ERR_NONE)); // R11

endmodule

// File: rtl/pbuf_ctrl.sv
module pbuf_ctrl
    import pbuf_pkg::*;
#(
    parameter int NB        = 5,
    parameter int BW        = 64,
    parameter int SCRAMBLED = 1,
    localparam int CW       = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_req_i,
    output logic             init_done_o,
    input  logic             integ_req_i,
    input  logic             cnsty_req_i,
    output logic             chk_ack_o,
    input  logic             esc_i,
    output logic             mem_req_o,
    output logic [CW-1:0]    mem_addr_o,
    input  logic             mem_gnt_i,
    input  logic             mem_rvalid_i,
    input  logic [BW-1:0]    mem_rdata_i,
    input  logic [1:0]       mem_status_i,
    output logic             mtx_req_o,
    input  logic             scr_gnt_i,
    input  logic             scr_ready_i,
    output logic             scr_vld_o,
    output logic [1:0]       scr_cmd_o,
    output logic [2*BW-1:0]  scr_data_o,
    input  logic             scr_vld_i,
    input  logic [BW-1:0]    scr_data_i,
    output logic [NB*BW-1:0] data_o,
    output logic [1:0]       err_o,
    output logic [7:0]       rd_lock_o,
    output logic [7:0]       wr_lock_o
);
    localparam logic [CW-1:0] LAST = CW'(NB - 1);
    localparam logic [CW-1:0] PEN  = CW'(NB - 2);
    localparam bit DESCR_ON = (SCRAMBLED != 0);

    st_e state_q, state_d;
    logic [CW-1:0] cnt;
    logic cnt_clr, cnt_inc, cnt_err;
    logic we;
    logic [BW-1:0] wdata, rblk, digest, lo_q;
    logic lo_ld, pass, done_q, ack_q;
    logic set_ecc, set_chk, set_fsm;
    err_e err;
    logic xfer, dig_ok;

    assign xfer   = scr_gnt_i && scr_ready_i;
    assign dig_ok = (digest == '0);

    pbuf_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt), .err(cnt_err)
    );

    pbuf_store #(.NB(NB), .BW(BW), .CW(CW)) u_store (
        .clk(clk), .rst(rst), .we(we), .widx(cnt), .wdata(wdata), .ridx(cnt),
        .done(done_q), .rblk(rblk), .digest(digest), .data_o(data_o)
    );

    pbuf_err u_err (
        .clk(clk), .rst(rst), .set_ecc(set_ecc), .set_chk(set_chk),
        .set_fsm(set_fsm), .err(err)
    );

    always_comb begin
        state_d    = state_q;
        mem_req_o  = 1'b0;
        mtx_req_o  = 1'b0;
        scr_vld_o  = 1'b0;
        scr_cmd_o  = CMD_DESCR;
        scr_data_o = {{BW{1'b0}}, rblk};
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        we         = 1'b0;
        wdata      = mem_rdata_i;
        lo_ld      = 1'b0;
        pass       = 1'b0;
        set_ecc    = 1'b0;
        set_chk    = 1'b0;
        set_fsm    = 1'b0;
        unique case (state_q)
            S_RESET: if (init_req_i) begin
                state_d = S_RD;
                cnt_clr = 1'b1;
            end
            S_RD: begin
                mem_req_o = 1'b1;
                if (mem_gnt_i) state_d = S_RDW;
            end
            S_RDW: if (mem_rvalid_i) begin
                if (!read_ok(mem_status_i)) begin
                    set_chk = 1'b1;
                    state_d = S_ERR;
                end else begin
                    set_ecc = (mem_status_i == 2'd1);
                    we      = 1'b1;
                    if (cnt == LAST) state_d = S_DIGCLR;
                    else if (DESCR_ON) state_d = S_DSC;
                    else begin
                        cnt_inc = 1'b1;
                        state_d = S_RD;
                    end
                end
            end
            S_DSC: begin
                mtx_req_o = 1'b1;
                scr_vld_o = 1'b1;
                if (xfer) state_d = S_DSCW;
            end
            S_DSCW: begin
                mtx_req_o = 1'b1;
                if (scr_vld_i) begin
                    we      = 1'b1;
                    wdata   = scr_data_i;
                    cnt_inc = 1'b1;
                    state_d = S_RD;
                end
            end
            S_DIGCLR: begin
                cnt_clr = 1'b1;
                state_d = S_DIG;
            end
            S_DIG: begin
                mtx_req_o = 1'b1;
                if (!cnt[0]) begin
                    lo_ld   = 1'b1;
                    cnt_inc = 1'b1;
                end else begin
                    scr_vld_o  = 1'b1;
                    scr_cmd_o  = CMD_ABSORB;
                    scr_data_o = {rblk, lo_q};
                    if (xfer) begin
                        if (cnt == PEN) state_d = S_FIN;
                        else cnt_inc = 1'b1;
                    end
                end
            end
            S_FIN: begin
                mtx_req_o  = 1'b1;
                scr_vld_o  = 1'b1;
                scr_cmd_o  = CMD_FINAL;
                scr_data_o = '0;
                if (xfer) state_d = S_FINW;
            end
            S_FINW: begin
                mtx_req_o = 1'b1;
                if (scr_vld_i) begin
                    if (scr_data_i == digest || dig_ok) begin
                        pass    = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        set_chk = 1'b1;
                        state_d = S_ERR;
                    end
                end
            end
            S_IDLE: begin
                if (integ_req_i) state_d = S_DIGCLR;
                else if (cnsty_req_i) state_d = S_CNRD;
            end
            S_CNRD: begin
                mem_req_o = 1'b1;
                if (mem_gnt_i) state_d = S_CNRDW;
            end
            S_CNRDW: if (mem_rvalid_i) begin
                if (!read_ok(mem_status_i)) begin
                    set_chk = 1'b1;
                    state_d = S_ERR;
                end else begin
                    set_ecc = (mem_status_i == 2'd1);
                    if (mem_rdata_i == digest || dig_ok) begin
                        pass    = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        set_chk = 1'b1;
                        state_d = S_ERR;
                    end
                end
            end
            S_ERR: ;
            default: begin
                state_d = S_ERR;
                set_fsm = 1'b1;
            end
        endcase
        if (esc_i || cnt_err) begin
            state_d = S_ERR;
            set_fsm = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_RESET;
            lo_q    <= '0;
            done_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (lo_ld) lo_q <= rblk;
            if (pass) done_q <= 1'b1;
            ack_q <= pass && done_q;
        end
    end

    assign mem_addr_o  = (state_q == S_CNRD) ? LAST : cnt;
    assign init_done_o = done_q;
    assign chk_ack_o   = ack_q;
    assign err_o       = err;
    assign rd_lock_o   = lock_code(!dig_ok);
    assign wr_lock_o   = lock_code(!dig_ok);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_q |=> done_q); // R6
    AST_ERR_TERMINAL: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ERR) |=> (state_q == S_ERR)); // R12
    AST_ACK_IN_IDLE: assert property (@(posedge clk) disable iff (rst)
        chk_ack_o |-> (state_q == S_IDLE)); // R8
    AST_ESC_HALT: assert property (@(posedge clk) disable iff (rst)
        esc_i |=> (state_q == S_ERR)); // R11
    AST_XFER_GATED: assert property (@(posedge clk) disable iff (rst)
        (scr_vld_o && !(scr_gnt_i && scr_ready_i)) |=> $stable(state_q)); // R5

endmodule

// File: tb/pbuf_ctrl_test.sv
module pbuf_ctrl_test;
    localparam int NB = 5;
    localparam int BW = 64;
    localparam int CW = $clog2(NB);
    localparam logic [BW-1:0] KEY  = 64'h0F1E_2D3C_4B5A_6978;
    localparam logic [BW-1:0] FINK = 64'hA5A5_5A5A_C3C3_3C3C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic init_req = 0, integ_req = 0, cnsty_req = 0, esc = 0;
    logic init_done, chk_ack, mem_req, mem_gnt, mem_rvalid, mtx_req, scr_gnt, scr_ready;
    logic scr_vld_o, scr_vld_i;
    logic [CW-1:0] mem_addr;
    logic [BW-1:0] mem_rdata, scr_data_i;
    logic [1:0] mem_status, scr_cmd, err;
    logic [2*BW-1:0] scr_data_o;
    logic [NB*BW-1:0] data;
    logic [7:0] rd_lock, wr_lock;

    logic gnt_en = 1, mtx_en = 1, rdy_en = 1;
    logic [BW-1:0] mem [NB];
    logic [1:0] stat [NB];
    logic [BW-1:0] plain [NB];
    logic [BW-1:0] acc;

    int checks = 0;
    int errors = 0;

    pbuf_ctrl #(.NB(NB), .BW(BW), .SCRAMBLED(1)) uut (
        .clk(clk), .rst(rst), .init_req_i(init_req), .init_done_o(init_done),
        .integ_req_i(integ_req), .cnsty_req_i(cnsty_req), .chk_ack_o(chk_ack),
        .esc_i(esc), .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_gnt_i(mem_gnt),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_status_i(mem_status),
        .mtx_req_o(mtx_req), .scr_gnt_i(scr_gnt), .scr_ready_i(scr_ready),
        .scr_vld_o(scr_vld_o), .scr_cmd_o(scr_cmd), .scr_data_o(scr_data_o),
        .scr_vld_i(scr_vld_i), .scr_data_i(scr_data_i), .data_o(data), .err_o(err),
        .rd_lock_o(rd_lock), .wr_lock_o(wr_lock)
    );

    function automatic logic [BW-1:0] mix(input logic [BW-1:0] a, lo, hi);
        return {a[BW-2:0], a[BW-1]} ^ lo ^ {hi[31:0], hi[63:32]};
    endfunction

    // memory model
    assign mem_gnt = mem_req && gnt_en;
    always @(posedge clk) begin
        mem_rvalid <= mem_req && mem_gnt;
        mem_rdata  <= mem[mem_addr];
        mem_status <= stat[mem_addr];
    end

    // engine model
    assign scr_gnt   = mtx_req && mtx_en;
    assign scr_ready = rdy_en;
    always @(posedge clk) begin
        scr_vld_i <= 1'b0;
        if (rst) acc <= '0;
        else if (scr_vld_o && scr_gnt && scr_ready) begin
            if (scr_cmd == 2'd0) begin
                scr_vld_i  <= 1'b1;
                scr_data_i <= scr_data_o[BW-1:0] ^ KEY;
            end else if (scr_cmd == 2'd1) begin
                acc <= mix(acc, scr_data_o[BW-1:0], scr_data_o[2*BW-1:BW]);
            end else begin
                scr_vld_i  <= 1'b1;
                scr_data_i <= acc ^ FINK;
                acc        <= '0;
            end
        end
    end

    function automatic logic [BW-1:0] calc_digest();
        logic [BW-1:0] a = '0;
        for (int i = 0; i + 1 < NB - 1; i += 2) a = mix(a, plain[i], plain[i+1]);
        return a ^ FINK;
    endfunction

    task automatic check(input string tag, input logic [NB*BW-1:0] act, input logic [NB*BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int seed, input bit zero_dig);
        for (int i = 0; i < NB - 1; i++) begin
            plain[i] = {32'hA0B0_0000 + 32'(i), 32'h1234_5678 ^ (32'(seed) * 32'h9E37_79B9 + 32'(i))};
            mem[i]   = plain[i] ^ KEY;
            stat[i]  = 2'd0;
        end
        plain[NB-1] = zero_dig ? '0 : calc_digest();
        mem[NB-1]   = plain[NB-1];
        stat[NB-1]  = 2'd0;
    endtask

    function automatic logic [NB*BW-1:0] expect_data();
        logic [NB*BW-1:0] v;
        for (int i = 0; i < NB; i++) v[i*BW +: BW] = plain[i];
        return v;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1; init_req = 0; integ_req = 0; cnsty_req = 0; esc = 0;
        gnt_en = 1; mtx_en = 1; rdy_en = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    task automatic pulse_init();
        init_req = 1; @(negedge clk); init_req = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 300 && !init_done; i++) @(negedge clk);
    endtask

    task automatic run_check(input bit integ, output bit acked);
        acked = 0;
        if (integ) integ_req = 1; else cnsty_req = 1;
        @(negedge clk);
        integ_req = 0; cnsty_req = 0;
        for (int i = 0; i < 200 && !acked; i++) begin
            if (chk_ack) acked = 1;
            @(negedge clk);
        end
    endtask

    task automatic check_dead(input string tag);
        int seen = 0;
        integ_req = 1; cnsty_req = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (mem_req || mtx_req || chk_ack) seen++;
        end
        integ_req = 0; cnsty_req = 0;
        check(tag, seen, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 init_done in reset", init_done, 0);
        check("R1 err in reset", err, 0);
        check("R1 mem_req in reset", mem_req, 0);
        check("R1 rd_lock in reset", rd_lock, 8'h69);
        check("R1 wr_lock in reset", wr_lock, 8'h69);
        check("R2 default data", data, {(NB*BW/8){8'hC3}});
    endtask

    task automatic t_init_ecc();
        bit a;
        do_reset();
        load(1, 0);
        stat[1] = 2'd1;
        pulse_init();
        wait_done();
        check("R6 init completes", init_done, 1);
        check("R2 buffered data", data, expect_data());
        check("R4 corrected code", err, 1);
        check("R10 rd_lock nonzero digest", rd_lock, 8'h96);
        check("R10 wr_lock nonzero digest", wr_lock, 8'h96);
        run_check(0, a);
        check("R8 consistency pass ack", a, 1);
        run_check(1, a);
        check("R9 integrity pass ack", a, 1);
        check("R9 code kept", err, 1);
        mem[NB-1] = mem[NB-1] ^ 64'h1;
        run_check(0, a);
        check("R8 consistency mismatch no ack", a, 0);
        check("R13 check-fail replaces corrected", err, 2);
        check_dead("R12 no activity in error");
    endtask

    task automatic t_zero_digest();
        bit a;
        do_reset();
        load(2, 1);
        pulse_init();
        wait_done();
        check("R6 zero digest bypass", init_done, 1);
        check("R10 lock off zero digest", rd_lock, 8'h69);
        check("R2 data with zero digest", data, expect_data());
        mem[NB-1] = 64'h0BAD_CAFE_0000_0001;
        run_check(0, a);
        check("R8 zero digest consistency bypass", a, 1);
        check("R8 code clean", err, 0);
    endtask

    task automatic t_uncorr();
        do_reset();
        load(3, 0);
        stat[2] = 2'd2;
        gnt_en = 0;
        pulse_init();
        repeat (5) @(negedge clk);
        check("R3 request held without grant", mem_req, 1);
        gnt_en = 1;
        repeat (150) @(negedge clk);
        check("R3 uncorrectable code", err, 2);
        check("R3 init not done", init_done, 0);
        check("R2 default after failed init", data, {(NB*BW/8){8'hC3}});
    endtask

    task automatic t_integ_fail();
        do_reset();
        load(4, 0);
        mem[NB-1] = mem[NB-1] ^ 64'h8000_0000_0000_0000;
        pulse_init();
        repeat (200) @(negedge clk);
        check("R7 mismatch code", err, 2);
        check("R7 init not done", init_done, 0);
        check_dead("R12 terminal after integrity fail");
    endtask

    task automatic t_escalate();
        bit a;
        do_reset();
        load(5, 0);
        pulse_init();
        wait_done();
        check("R11 clean before escalation", err, 0);
        esc = 1; @(negedge clk); esc = 0;
        @(negedge clk);
        check("R11 fsm code recorded", err, 3);
        check_dead("R12 terminal after escalation");
        do_reset();
        load(6, 0);
        stat[0] = 2'd1;
        pulse_init();
        wait_done();
        esc = 1; @(negedge clk); esc = 0;
        @(negedge clk);
        check("R11 earlier code kept", err, 1);
        run_check(0, a);
        check("R12 no ack after escalation", a, 0);
    endtask

    task automatic t_stall();
        do_reset();
        load(7, 0);
        mtx_en = 0;
        pulse_init();
        repeat (40) @(negedge clk);
        check("R5 stalled without mutex grant", init_done, 0);
        check("R5 command waiting", scr_vld_o, 1);
        mtx_en = 1; rdy_en = 0;
        repeat (40) @(negedge clk);
        check("R5 stalled without ready", init_done, 0);
        rdy_en = 1;
        wait_done();
        check("R5 completes after release", init_done, 1);
        check("R5 data after stall", data, expect_data());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NB; i++) begin mem[i] = '0; stat[i] = '0; plain[i] = '0; end
        repeat (2) @(negedge clk);
        t_reset();
        rst = 0;
        t_init_ecc();
        t_zero_digest();
        t_uncorr();
        t_integ_fail();
        t_escalate();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule